// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns one burst request into the series of column addresses that a synchronous DRAM array walks through during a read or write burst. A request gives a start column, a burst length code and an ordering select. The block then presents one column address per accepted beat on a valid/ready output stream, and marks the final beat of a fixed-length burst.

Two orderings are supported for fixed bursts of 1, 2, 4 and 8 beats. In sequential order the low column bits count up and wrap inside the aligned group. In interleaved order the low bits are the start bits XORed with the beat index. An open-ended page mode, allowed only with sequential order, steps the whole column address and wraps at the end of the page. It runs until the stop input ends it. A command sequencer drives the start pulse and the stop input, and consumes the address stream.

Output back-pressure rules: a beat is consumed on a clock edge where `col_valid` and `col_ready` are both high. While `col_ready` is low the presented address and last flag hold. `col_valid` does not depend on `col_ready`. The request side has no back-pressure: a legal start is always taken at once.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `col_valid`, `col_last` and `cfg_illegal` are low.
- R2: Length codes on `start_len` are 0 for 1 beat, 1 for 2 beats, 2 for 4 beats, 3 for 8 beats and 7 for page mode. On the cycle after a legal `start`, `col_valid` is high and `col_addr` equals `start_col`.
- R3: With `start_ilv` = 0 and a burst of N beats, beat k carries the upper column bits of the start column unchanged. Its low log2(N) bits are (start low bits + k) modulo N.
- R4: With `start_ilv` = 1 and a burst of N beats, beat k carries the upper column bits unchanged. Its low log2(N) bits are the start low bits XOR k.
- R5: In page mode the whole column address increments by one per consumed beat and wraps from the top column to 0. `col_last` is never raised in page mode.
- R6: When `stop` is high on a clock edge without `start`, `col_valid` is low after that edge, in any mode.
- R7: `col_last` is high on the final beat of a 1, 2, 4 or 8 beat burst and only there. After that beat is consumed, `col_valid` goes low. A 1-beat burst yields one beat, with `col_last` high.
- R8: While `col_valid` is high and `col_ready` is low, `col_addr` and `col_last` hold. The beat index advances only on a handshake.
- R9: A legal `start` during an active burst abandons it. On the next cycle the block presents the first beat of the new burst.
- R10: A request that selects interleave with page mode, or one that uses length code 4, 5 or 6, is illegal. It raises `cfg_illegal` for exactly the next cycle. It starts nothing, and it leaves any active burst running unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request pulse |
| start_col | input | COL_W | Start column of the request |
| start_len | input | 3 | Burst length code |
| start_ilv | input | 1 | 1 selects interleaved order, 0 sequential |
| stop | input | 1 | Terminates the active burst |
| col_ready | input | 1 | Consumer accepts the presented beat |
| col_valid | output | 1 | A column address is presented |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one of a fixed burst |
| cfg_illegal | output | 1 | One-cycle flag for a rejected request |

## Verification
The hardest situations to reach from the ports are those where a new request or a stop lands on a burst that is part-way through. The second request must hit an exact beat. The bench holds `col_ready` high during those phases, so the beat count after the start pulse is known. It then places the second `start`, or the `stop`, on the negative edge that precedes the chosen beat's handshake. The scoreboard is given only the beats that should appear before the cut. Wrap cases in page mode start a few columns below the top of the page. Back-pressure runs use a pseudo-random ready pattern, which the stable-hold assertion watches.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // burst length codes seen on start_len
  localparam logic [2:0] LEN_1    = 3'd0;
  localparam logic [2:0] LEN_2    = 3'd1;
  localparam logic [2:0] LEN_4    = 3'd2;
  localparam logic [2:0] LEN_8    = 3'd3;
  localparam logic [2:0] LEN_PAGE = 3'd7;
  localparam int LEN_CODE_W = 3;

  typedef enum logic [1:0] {
    ORD_SEQ  = 2'd0,
    ORD_ILV  = 2'd1,
    ORD_PAGE = 2'd2
  } order_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  ilv,
  output logic [COL_W-1:0]      wrap_mask,
  output order_e                order,
  output logic                  legal
);
  localparam int FIXED_CODES = 4;

  logic [FIXED_CODES-1:0] hit;

  // one-hot decode of the fixed lengths, mask = N-1
  generate
    for (genvar g = 0; g < FIXED_CODES; g++) begin : g_fixed
      assign hit[g] = (len_code == LEN_CODE_W'(g));
    end
  endgenerate

  always_comb begin
    wrap_mask = '0;
    for (int i = 0; i < FIXED_CODES; i++) begin
      if (hit[i]) wrap_mask = COL_W'((1 << i) - 1);
    end
    if (len_code == LEN_PAGE) wrap_mask = '1;
  end

  always_comb begin
    legal = 1'b0;
    order = ORD_SEQ;
    if (|hit) begin
      legal = 1'b1;
      order = ilv ? ORD_ILV : ORD_SEQ;
    end else if (len_code == LEN_PAGE && !ilv) begin
      legal = 1'b1;
      order = ORD_PAGE;
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_idx,
  input  logic [COL_W-1:0] wrap_mask,
  input  order_e           order,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] sum_col;
  logic [COL_W-1:0] xor_col;

  assign sum_col = base_col + beat_idx;
  assign xor_col = base_col ^ beat_idx;

  // bits outside the mask come from the base, bits inside from the chosen walk
  always_comb begin
    unique case (order)
      ORD_ILV:  addr = (base_col & ~wrap_mask) | (xor_col & wrap_mask);
      ORD_PAGE: addr = sum_col;
      default:  addr = (base_col & ~wrap_mask) | (sum_col & wrap_mask);
    endcase
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] start_len,
  input  logic                  start_ilv,
  input  logic                  stop,
  input  logic                  col_ready,
  output logic                  col_valid,
  output logic [COL_W-1:0]      col_addr,
  output logic                  col_last,
  output logic                  cfg_illegal
);
  logic [COL_W-1:0] dec_mask;
  order_e           dec_order;
  logic             dec_legal;

  logic             active_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  order_e           order_q;
  logic             illegal_q;
  logic             final_beat;
  logic             take_req;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code  (start_len),
    .ilv       (start_ilv),
    .wrap_mask (dec_mask),
    .order     (dec_order),
    .legal     (dec_legal)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_gen (
    .base_col  (base_q),
    .beat_idx  (beat_q),
    .wrap_mask (mask_q),
    .order     (order_q),
    .addr      (col_addr)
  );

  assign take_req   = start && dec_legal;
  assign final_beat = (order_q != ORD_PAGE) && (beat_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      base_q    <= '0;
      beat_q    <= '0;
      mask_q    <= '0;
      order_q   <= ORD_SEQ;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= start && !dec_legal;
      if (take_req) begin
        active_q <= 1'b1;
        base_q   <= start_col;
        beat_q   <= '0;
        mask_q   <= dec_mask;
        order_q  <= dec_order;
      end else if (stop) begin
        active_q <= 1'b0;
      end else if (active_q && col_ready) begin
        if (final_beat) active_q <= 1'b0;
        else            beat_q   <= beat_q + 1'b1;
      end
    end
  end

  assign col_valid   = active_q;
  assign col_last    = active_q && final_beat;
  assign cfg_illegal = illegal_q;
endmodule

module burst_col_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [COL_W-1:0]      start_col,
  input logic [LEN_CODE_W-1:0] start_len,
  input logic                  start_ilv,
  input logic                  stop,
  input logic                  col_ready,
  input logic                  col_valid,
  input logic [COL_W-1:0]      col_addr,
  input logic                  col_last,
  input logic                  cfg_illegal
);
  logic req_ok;
  assign req_ok = start && ((start_len <= LEN_8) || (start_len == LEN_PAGE && !start_ilv));

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok |=> (col_valid && col_addr == $past(start_col)));

  // R6
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !col_valid);

  // R7
  last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && col_ready && !start && !stop) |=> !col_valid);

  // R7
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && start_len == LEN_1) |=> col_last);

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready && !start && !stop) |=> (col_valid && $stable(col_addr) && $stable(col_last)));

  // R10
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !req_ok) |=> cfg_illegal);

  // R10
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start) |=> !cfg_illegal);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
  .start_len(start_len), .start_ilv(start_ilv), .stop(stop),
  .col_ready(col_ready), .col_valid(col_valid), .col_addr(col_addr),
  .col_last(col_last), .cfg_illegal(cfg_illegal)
);

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
  localparam int COL_W = 10;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       start_len = '0;
  logic             start_ilv = 1'b0;
  logic             stop = 1'b0;
  logic             col_ready = 1'b1;
  logic             col_valid;
  logic [COL_W-1:0] col_addr;
  logic             col_last;
  logic             cfg_illegal;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  bp_en    = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  typedef struct {
    logic [COL_W-1:0] addr;
    logic             last;
    string            tag;
  } beat_t;
  beat_t exp_q[$];

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .start_len(start_len), .start_ilv(start_ilv), .stop(stop),
    .col_ready(col_ready), .col_valid(col_valid), .col_addr(col_addr),
    .col_last(col_last), .cfg_illegal(cfg_illegal)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ready pattern, updated just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    col_ready <= bp_en ? lfsr[0] : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && col_valid && col_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected beat", int'(col_addr), 0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        check(col_addr == e.addr, {e.tag, " addr"}, int'(col_addr), int'(e.addr));
        check(col_last == e.last, {e.tag, " last"}, int'(col_last), int'(e.last));
      end
    end
  end

  function automatic logic [COL_W-1:0] model_col(int base, int k, int n, bit ilv);
    int lo, up;
    if (n == 0) return COL_W'((base + k) % PAGE);
    lo = base % n;
    up = base - lo;
    return COL_W'(up + (ilv ? (lo ^ k) : ((lo + k) % n)));
  endfunction

  task automatic push_burst(input int base, input int code, input bit ilv, input int cnt, input string tag);
    int n;
    n = (code == 7) ? 0 : (1 << code);
    for (int k = 0; k < cnt; k++) begin
      beat_t e;
      e.addr = model_col(base, k, n, ilv);
      e.last = (code != 7) && (k == n - 1);
      e.tag  = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic start_req(input int col, input int code, input bit ilv);
    @(negedge clk);
    start_col = COL_W'(col);
    start_len = 3'(code);
    start_ilv = ilv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain(input string tag);
    @(posedge clk);
    while (exp_q.size() != 0) @(posedge clk);
    @(negedge clk);
    check(col_valid == 1'b0, {tag, " valid low after final beat"}, int'(col_valid), 0);
  endtask

  task automatic run_burst(input int col, input int code, input bit ilv, input string tag);
    push_burst(col, code, ilv, (code == 7) ? 0 : (1 << code), tag);
    start_req(col, code, ilv);
    drain(tag);
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(col_valid == 1'b0, "R1 valid", int'(col_valid), 0);
    check(col_last == 1'b0, "R1 last", int'(col_last), 0);
    check(cfg_illegal == 1'b0, "R1 illegal", int'(cfg_illegal), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 sequential bursts
    run_burst(10'h05D, 3, 1'b0, "R3 seq8");
    run_burst(10'h0FF, 1, 1'b0, "R3 seq2");
    run_burst(10'h2B6, 2, 1'b0, "R2 seq4");
    // R4 interleaved bursts
    run_burst(10'h1A6, 2, 1'b1, "R4 ilv4");
    run_burst(10'h3F3, 3, 1'b1, "R4 ilv8");
    run_burst(10'h001, 1, 1'b1, "R4 ilv2");
    // R7 single beat
    run_burst(10'h123, 0, 1'b0, "R7 bl1");
    run_burst(10'h3FF, 0, 1'b1, "R7 bl1 ilv");

    // R8 back-pressure
    bp_en = 1'b1;
    run_burst(10'h2A9, 3, 1'b0, "R8 seq8 stall");
    run_burst(10'h011, 2, 1'b1, "R8 ilv4 stall");
    run_burst(10'h0C5, 3, 1'b1, "R8 ilv8 stall");
    bp_en = 1'b0;
    repeat (2) @(negedge clk);

    // R5 R6 page mode wrapping then stopped after 8 beats
    push_burst(10'h3FC, 7, 1'b0, 8, "R5 page wrap");
    start_req(10'h3FC, 7, 1'b0);
    repeat (7) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(col_valid == 1'b0, "R6 page stop", int'(col_valid), 0);
    check(exp_q.size() == 0, "R5 page beats", exp_q.size(), 0);

    // R6 stop in a fixed burst after 3 beats
    push_burst(10'h200, 3, 1'b0, 3, "R6 fixed stop");
    start_req(10'h200, 3, 1'b0);
    repeat (2) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(col_valid == 1'b0, "R6 fixed stop", int'(col_valid), 0);
    check(exp_q.size() == 0, "R6 beats before stop", exp_q.size(), 0);

    // R9 restart after 3 beats of an 8-beat burst
    push_burst(10'h040, 3, 1'b0, 3, "R9 first");
    push_burst(10'h10E, 2, 1'b0, 4, "R9 second");
    start_req(10'h040, 3, 1'b0);
    repeat (1) @(negedge clk);
    start_req(10'h10E, 2, 1'b0);
    drain("R9");

    // R10 illegal requests while idle
    start_req(10'h055, 7, 1'b1);
    check(cfg_illegal == 1'b1, "R10 ilv page flag", int'(cfg_illegal), 1);
    check(col_valid == 1'b0, "R10 ilv page no burst", int'(col_valid), 0);
    @(negedge clk);
    check(cfg_illegal == 1'b0, "R10 flag one cycle", int'(cfg_illegal), 0);
    start_req(10'h077, 5, 1'b0);
    check(cfg_illegal == 1'b1, "R10 reserved code flag", int'(cfg_illegal), 1);
    check(col_valid == 1'b0, "R10 reserved no burst", int'(col_valid), 0);

    // R10 illegal request during an active burst leaves it running
    push_burst(10'h080, 3, 1'b0, 8, "R10 burst unaffected");
    start_req(10'h080, 3, 1'b0);
    start_req(10'h3C0, 4, 1'b0);
    drain("R10");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 scoreboard empty", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule